// File: doc/BRIEF.md
# Tri-State Phase Frequency Detector

The detector compares two divided clocks of a frequency synthesizer loop: the divided oscillator signal and the divided reference signal, both arriving as logic levels synchronous to the system clock. A rising edge on either one sets its own flag. When both flags are set they clear together. The flag that was set first marks which signal is ahead. Its duration is the phase error.

The error is reported in three forms. The first is a single-ended three-state output, modelled as an enable and a data bit. It drives low while the oscillator side leads, drives high while it lags, and is released (enable low) when neither or both flags are set. The second is a pair of active-low pulse outputs, one per flag. The third is a lock flag. At the close of each comparison the lock flag takes a verdict on that comparison, and it drops at once when one flag has stayed set alone for longer than a set number of clock cycles.

Top module: `phase_freq_detector`

## Requirements
- R1: A rising edge (0 to 1 between two clock samples) on `fvco_in` sets the oscillator flag at the next clock edge, and a rising edge on `fref_in` sets the reference flag the same way. A set flag stays set until the clearing in R2.
- R2: In a cycle where both flags are set, both clear at the next edge. A rising edge that arrives in that same cycle sets its flag again instead.
- R3: With only the oscillator flag set, `pd_oe` is 1 and `pd_out` is 0 (a low pulse: the oscillator leads or runs fast).
- R4: With only the reference flag set, `pd_oe` is 1 and `pd_out` is 1 (a high pulse: the oscillator lags or runs slow).
- R5: With neither flag set or with both set, `pd_oe` is 0 (high impedance) and `pd_out` is 0.
- R6: `up_n` is 0 exactly while the oscillator flag is set, and `dn_n` is 0 exactly while the reference flag is set.
- R7: When one flag has been set alone for LOCK_TOL consecutive cycles and is still set alone in the next cycle, `lock` is 0 from the following edge onward.
- R8: In a cycle with both flags set, `lock` becomes 1 at the next edge if the comparison now ending never broke the limit of R7. Otherwise it becomes 0. Outside the cases of R7 and R8, `lock` holds its value.
- R9: While `rst_n` is 0 at a clock edge, both flags clear, `lock` becomes 0, `pd_oe` is 0, and `up_n` and `dn_n` are 1.
- R10: An input held at 1 for many cycles sets its flag only once. After that flag is cleared it stays clear until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fvco_in | input | 1 | Divided oscillator signal (level) |
| fref_in | input | 1 | Divided reference signal (level) |
| pd_out | output | 1 | Data of the three-state error output |
| pd_oe | output | 1 | Enable of the three-state error output |
| up_n | output | 1 | Active-low pulse while the oscillator flag is set |
| dn_n | output | 1 | Active-low pulse while the reference flag is set |
| lock | output | 1 | Lock indication |

## Verification
The bench targets an edge that lands in the clearing cycle. A design that gives priority to the clear would drop that edge, and the next comparison would run one period short. Inputs held high test the edge detection: a level-sensitive design would set its flag again straight after the clear and leave the error output stuck active. The lock limit is tested one cycle below and one cycle at the threshold, which catches an off-by-one in the run counter, and simultaneous edges must never enable the error output. Long runs of square waves at unequal and then equal periods are compared on every cycle against a behavioural model. These runs would expose a wrong error polarity, swapped pulse outputs, or a lock flag that recovers during a comparison instead of at its close.

// File: rtl/pfd_pkg.sv
// Package: shared flag type and helpers for the phase frequency detector.
// Assumes nothing beyond a single clock domain for all users.
package pfd_pkg;

    // Pair of edge flags: v for the oscillator side, r for the reference side.
    typedef struct packed {
        logic v;
        logic r;
    } pfd_flags_t;

    // True when exactly one flag is set (an error pulse is in progress).
    function automatic logic flags_alone(input pfd_flags_t f);
        return f.v ^ f.r;
    endfunction

    // True when both flags are set (the comparison is closing).
    function automatic logic flags_both(input pfd_flags_t f);
        return f.v & f.r;
    endfunction

endpackage

// File: rtl/pfd_edge_detect.sv
// Rising-edge detector over WIDTH level inputs.
// Does: registers each input once and flags a 0-to-1 change in the current cycle.
// Assumes: inputs are already synchronous to clk.
module pfd_edge_detect #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] prev_q;

    // Keep last cycle's level of every input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    // One rise bit per input, generated per lane.
    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        assign rise_o[g] = level_i[g] & ~prev_q[g];
    end

    // A reported rise must not repeat in the following cycle if the level stays high.
    AST_NO_DOUBLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o[0] && level_i[0]) |=> (!level_i[0] || !rise_o[0])); // R10

endmodule

// File: rtl/pfd_flipflops.sv
// Edge flip-flop pair with mutual clearing.
// Does: sets a flag on its edge and clears both once both are set. An edge in the
// clearing cycle re-arms its flag so no comparison edge is lost.
// Assumes: rise inputs are single-cycle pulses from pfd_edge_detect.
module pfd_flipflops
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_v_i,
    input  logic       rise_r_i,
    output pfd_flags_t flags_o
);

    pfd_flags_t flags_q;
    logic       closing;

    assign closing = flags_both(flags_q);

    // Set on edge, hold while alone, clear (or re-arm) when both are set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (closing) begin
            flags_q.v <= rise_v_i;
            flags_q.r <= rise_r_i;
        end else begin
            flags_q.v <= flags_q.v | rise_v_i;
            flags_q.r <= flags_q.r | rise_r_i;
        end
    end

    assign flags_o = flags_q;

    AST_SET_V: assert property (@(posedge clk) disable iff (!rst_n)
        rise_v_i |=> flags_q.v); // R1
    AST_SET_R: assert property (@(posedge clk) disable iff (!rst_n)
        rise_r_i |=> flags_q.r); // R1
    AST_HOLD_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.v && !flags_q.r) |=> flags_q.v); // R1
    AST_MUTUAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.v && flags_q.r && !rise_v_i && !rise_r_i) |=> (!flags_q.v && !flags_q.r)); // R2

endmodule

// File: rtl/pfd_lock_detect.sv
// Lock detector.
// Does: counts consecutive single-flag cycles. It drops lock once the run goes past
// LOCK_TOL, and at each closing cycle it takes the verdict of the comparison just ended.
// Assumes: within one comparison the single-flag cycles form one contiguous run.
module pfd_lock_detect
    import pfd_pkg::*;
#(
    parameter int LOCK_TOL = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  pfd_flags_t flags_i,
    output logic       lock_o
);

    localparam int CW = $clog2(LOCK_TOL + 2);
    localparam logic [CW-1:0] RUN_MAX = CW'(LOCK_TOL + 1);
    localparam logic [CW-1:0] RUN_TOL = CW'(LOCK_TOL);

    logic [CW-1:0] run_q;
    logic          bad_q;
    logic          lock_q;
    logic          alone;
    logic          closing;
    logic          excess;

    assign alone   = flags_alone(flags_i);
    assign closing = flags_both(flags_i);
    assign excess  = alone && (run_q >= RUN_TOL);

    // Length of the current single-flag run, saturating above the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !alone) run_q <= '0;
        else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end

    // Remember a broken limit until the comparison closes.
    always_ff @(posedge clk) begin
        if (!rst_n || closing) bad_q <= 1'b0;
        else if (excess)       bad_q <= 1'b1;
    end

    // Lock verdict: drop on excess, decide at close, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= 1'b0;
        else if (closing) lock_q <= ~bad_q;
        else if (excess)  lock_q <= 1'b0;
    end

    assign lock_o = lock_q;

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_MAX); // R7
    AST_BAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        closing |=> !bad_q); // R8

endmodule

// File: rtl/phase_freq_detector.sv
// Tri-state phase frequency detector, top level.
// Does: detects edges on the two divided signals, runs the mutual-clear flag pair,
// and drives the three-state error pair, the two active-low pulses and lock.
// Assumes: fvco_in and fref_in are synchronous levels; the pad cell turns
// pd_oe/pd_out into a real three-state pin.
module phase_freq_detector
    import pfd_pkg::*;
#(
    parameter int LOCK_TOL = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fvco_in,
    input  logic fref_in,
    output logic pd_out,
    output logic pd_oe,
    output logic up_n,
    output logic dn_n,
    output logic lock
);

    localparam int LANES = 2;

    logic [LANES-1:0] rise;
    pfd_flags_t       flags;

    pfd_edge_detect #(.WIDTH(LANES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i ({fref_in, fvco_in}),
        .rise_o  (rise)
    );

    pfd_flipflops u_ff (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_v_i (rise[0]),
        .rise_r_i (rise[1]),
        .flags_o  (flags)
    );

    pfd_lock_detect #(.LOCK_TOL(LOCK_TOL)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags),
        .lock_o  (lock)
    );

    // Three-state encoding: drive only while one flag is alone; high means lagging.
    always_comb begin
        pd_oe  = flags_alone(flags);
        pd_out = flags.r & ~flags.v;
    end

    // Double-ended pulses, active low.
    always_comb begin
        up_n = ~flags.v;
        dn_n = ~flags.r;
    end

    AST_LEAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_n && dn_n) |-> (pd_oe && !pd_out)); // R3
    AST_LAG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (up_n && !dn_n) |-> (pd_oe && pd_out)); // R4
    AST_IDLE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_oe |-> !pd_out); // R5
    AST_LOCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> $past(pd_oe)); // R7
    AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(!up_n && !dn_n)); // R8

endmodule

// File: tb/sim_phase_freq_detector.sv
module sim_phase_freq_detector;

    localparam int CLK_PERIOD = 10;
    localparam int TOL = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fvco_in = 1'b0;
    logic fref_in = 1'b0;
    logic pd_out, pd_oe, up_n, dn_n, lock;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    phase_freq_detector #(.LOCK_TOL(TOL)) u0 (
        .clk(clk), .rst_n(rst_n), .fvco_in(fvco_in), .fref_in(fref_in),
        .pd_out(pd_out), .pd_oe(pd_oe), .up_n(up_n), .dn_n(dn_n), .lock(lock)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model, advanced on every rising edge.
    bit m_v, m_r, m_pv, m_pr, m_bad, m_lock;
    int m_run;
    always @(posedge clk) begin
        bit rv, rr, alone, both;
        if (!rst_n) begin
            m_v = 0; m_r = 0; m_pv = 0; m_pr = 0; m_bad = 0; m_lock = 0; m_run = 0;
        end else begin
            rv = fvco_in && !m_pv;
            rr = fref_in && !m_pr;
            alone = (m_v != m_r);
            both = m_v && m_r;
            if (both) begin
                m_lock = !m_bad; m_bad = 0;
            end else if (alone && m_run >= TOL) begin
                m_lock = 0; m_bad = 1;
            end
            m_run = alone ? m_run + 1 : 0;
            if (both) begin
                m_v = rv; m_r = rr;
            end else begin
                m_v = m_v || rv; m_r = m_r || rr;
            end
            m_pv = fvco_in; m_pr = fref_in;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 up_n", up_n, !m_v);
            chk("R6 dn_n", dn_n, !m_r);
            chk("R3/R4/R5 pd_oe", pd_oe, m_v != m_r);
            chk("R3/R4/R5 pd_out", pd_out, m_r && !m_v);
            chk("R7/R8 lock", lock, m_lock);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic quiet();
        fvco_in = 0; fref_in = 0;
        step(2);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        step(3);
        // R9: reset state
        chk("R9 pd_oe", pd_oe, 0);
        chk("R9 up_n", up_n, 1);
        chk("R9 dn_n", dn_n, 1);
        chk("R9 lock", lock, 0);
        rst_n = 1;
        step(2);

        // R1/R3: oscillator first, reference one cycle later -> lock good (R8)
        fvco_in = 1; step(1);
        chk("R1 up_n", up_n, 0);
        chk("R3 pd_oe", pd_oe, 1);
        chk("R3 pd_out", pd_out, 0);
        fref_in = 1; step(1);
        chk("R5 both pd_oe", pd_oe, 0);
        step(1);
        chk("R2 cleared up_n", up_n, 1);
        chk("R2 cleared dn_n", dn_n, 1);
        chk("R8 lock good", lock, 1);
        quiet();

        // R7: oscillator alone for two cycles breaks the limit
        fvco_in = 1; step(2);
        chk("R7 lock before limit", lock, 1);
        step(1);
        chk("R7 lock dropped", lock, 0);
        fref_in = 1; step(2);
        chk("R8 lock bad verdict", lock, 0);
        quiet();

        // R4: reference leads
        fref_in = 1; step(1);
        chk("R4 pd_oe", pd_oe, 1);
        chk("R4 pd_out", pd_out, 1);
        chk("R6 dn_n", dn_n, 0);
        fvco_in = 1; step(2);
        chk("R8 lock recovers", lock, 1);
        quiet();

        // R5: simultaneous edges never enable the output
        fvco_in = 1; fref_in = 1; step(1);
        chk("R5 simultaneous pd_oe", pd_oe, 0);
        chk("R5 simultaneous pd_out", pd_out, 0);
        step(1);
        chk("R5 after close pd_oe", pd_oe, 0);
        quiet();

        // R2: edge arriving in the clearing cycle re-arms its flag
        fvco_in = 1; step(1);
        fref_in = 1; fvco_in = 0; step(1);
        fvco_in = 1; step(1);
        chk("R2 rearm up_n", up_n, 0);
        chk("R2 rearm dn_n", dn_n, 1);
        fref_in = 0; step(1);
        fref_in = 1; step(2);
        quiet();

        // R10: held-high input sets its flag once only
        fvco_in = 1; step(4);
        fref_in = 1; step(2);
        chk("R10 held up_n", up_n, 1);
        chk("R10 held pd_oe", pd_oe, 0);
        step(5);
        chk("R10 still clear", up_n, 1);
        quiet();

        // Free-running square waves: unequal then equal periods
        for (int c = 0; c < 3000; c++) begin
            fvco_in = ((c / 7) % 2) == 1;
            fref_in = ((c / 8) % 2) == 1;
            step(1);
        end
        for (int c = 0; c < 2000; c++) begin
            fvco_in = (((c + 1) / 9) % 2) == 1;
            fref_in = ((c / 9) % 2) == 1;
            step(1);
        end
        for (int c = 0; c < 1000; c++) begin
            fvco_in = ((c / 6) % 2) == 1;
            fref_in = (((c + 3) / 6) % 2) == 1;
            step(1);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule